// File: doc/BRIEF.md
# Programmed-I/O Transfer FIFO with Command Capture

This block sits between a host byte-wide register port and the data path of a SCSI initiator during programmed-I/O transfers. It holds up to fifteen bytes in a sixteen-slot ring. The ring keeps a read pointer, a write pointer and an occupancy count. Host writes enter the ring and host reads drain it. Every successful read raises a one-cycle interrupt strobe. When the ring empties, both pointers return to slot zero.

A separate command-capture mode steers host writes into a dedicated command buffer with its own length counter, leaving the ring untouched. A phase input says whether a read should hand back real data: when the two upper phase bits are both zero the transfer direction is outbound, and reads return zero while still consuming an entry. A response-load strobe prepares the two-byte completion reply (status byte, then zero) in the ring and sets the flags register to two. A flush strobe empties the ring in one cycle.

Top module: `pio_xfer_fifo`

## Requirements
- R1: After reset, fifoCount, fifoFlags, rdData and cmdLen are 0, and overrunErr and irqPulse are low.
- R2: A host write with captureMode low, while fifoCount is below DEPTH-1, stores the byte at the tail of the ring. fifoCount rises by one at the next clock edge.
- R3: A host write with captureMode low, while fifoCount equals DEPTH-1 (15 by default), is refused. fifoCount does not change and overrunErr is high for exactly the following cycle.
- R4: A host write with captureMode high leaves fifoCount unchanged. It stores the byte at command-buffer index cmdLen (readable on cmdRdData through cmdRdIdx) and increments cmdLen. cmdLen saturates at CMD_DEPTH, and further capture writes are dropped.
- R5: A host read while fifoCount is non-zero decrements fifoCount and pulses irqPulse for one cycle. If phaseBits[2:1] is non-zero, rdData takes the oldest ring byte in the same cycle, so bytes leave in write order across pointer wrap.
- R6: A host read while phaseBits[2:1] equals 2'b00 still consumes an entry and pulses irqPulse, but rdData becomes 0.
- R7: A host read while fifoCount is 0 has no effect: rdData keeps its value, fifoCount stays 0 and irqPulse stays low.
- R8: Whenever fifoCount is 0, both ring pointers are 0. After a drain, the next write lands in slot zero and reads back correctly.
- R9: respLoad puts respStatus then 0x00 at the head of the ring, sets fifoCount to 2 and fifoFlags to 2, and returns both pointers to 0. It takes priority over host reads and ring writes in the same cycle.
- R10: flush sets fifoCount, fifoFlags and both pointers to 0 at the next edge. It takes priority over respLoad and over host ring traffic.
- R11: A host read and a ring write in the same cycle return the oldest byte and leave fifoCount unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host byte write strobe |
| hostWrData | input | 8 | Host write byte |
| hostRdEn | input | 1 | Host byte read strobe |
| captureMode | input | 1 | Steer host writes into the command buffer |
| phaseBits | input | 3 | Current bus phase; bits [2:1] zero means outbound |
| flush | input | 1 | Empty the ring |
| respLoad | input | 1 | Load the two-byte completion reply |
| respStatus | input | 8 | Status byte for the completion reply |
| cmdRdIdx | input | 4 | Command buffer read index |
| rdData | output | 8 | Last byte handed to the host |
| fifoCount | output | 5 | Ring occupancy |
| fifoFlags | output | 5 | Flags register (2 after a reply load) |
| overrunErr | output | 1 | One-cycle pulse on a refused write |
| irqPulse | output | 1 | One-cycle pulse per successful read |
| cmdLen | output | 5 | Command buffer length |
| cmdRdData | output | 8 | Command buffer byte at cmdRdIdx |

## Verification
The hardest state to reach is a wrapped ring whose write pointer has passed slot DEPTH-1 while entries are still pending. The pointers return to zero on every drain, so the ring wraps only if it never empties in between. The stimulus writes ten bytes, reads four and then writes eight more, so the tail crosses the end while fourteen bytes are still held. It then drains them and compares the order through the scoreboard. The overrun boundary is reached by filling exactly fifteen entries before one more write.

// File: rtl/pio_fifo_pkg.sv
package pio_fifo_pkg;

  localparam int PHASE_W = 3;

  // Per-cycle commands from control to datapath; mutually prioritised by control
  typedef struct packed {
    logic push;     // append host byte to ring
    logic pop;      // consume oldest ring byte
    logic popData;  // popped byte is real data (else zero)
    logic cmdPush;  // append host byte to command buffer
    logic clear;    // empty the ring
    logic loadResp; // load completion reply
  } fifoStrobes_t;

endpackage

// File: rtl/pio_fifo_ctrl.sv
module pio_fifo_ctrl
  import pio_fifo_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int CMD_DEPTH = 16,
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int CMDL_W   = $clog2(CMD_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWrEn,
  input  logic               hostRdEn,
  input  logic               captureMode,
  input  logic [PHASE_W-1:0] phaseBits,
  input  logic               flush,
  input  logic               respLoad,
  input  logic [CNT_W-1:0]   count,
  input  logic [CMDL_W-1:0]  cmdLen,
  output fifoStrobes_t       strobes,
  output logic               overrunErr,
  output logic               irqPulse
);

  localparam logic [CNT_W-1:0]  FULL_MARK = CNT_W'(DEPTH - 1);
  localparam logic [CMDL_W-1:0] CMD_LIMIT = CMDL_W'(CMD_DEPTH);

  logic ringWrite;
  logic refuse;

  always_comb begin
    ringWrite        = hostWrEn && !captureMode && !flush && !respLoad;
    refuse           = ringWrite && (count == FULL_MARK);
    strobes.clear    = flush;
    strobes.loadResp = respLoad && !flush;
    strobes.push     = ringWrite && !refuse;
    strobes.pop      = hostRdEn && !flush && !respLoad && (count != '0);
    strobes.popData  = |phaseBits[2:1];
    strobes.cmdPush  = hostWrEn && captureMode && (cmdLen != CMD_LIMIT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      overrunErr <= 1'b0;
      irqPulse   <= 1'b0;
    end else begin
      overrunErr <= refuse;
      irqPulse   <= strobes.pop;
    end
  end

endmodule

// File: rtl/pio_fifo_data.sv
module pio_fifo_data
  import pio_fifo_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int CMD_DEPTH = 16,
  parameter int W         = 8,
  localparam int PTR_W    = $clog2(DEPTH),
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int CPTR_W   = $clog2(CMD_DEPTH),
  localparam int CMDL_W   = $clog2(CMD_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobes_t      strobes,
  input  logic [W-1:0]      wrData,
  input  logic [W-1:0]      respStatus,
  input  logic [CPTR_W-1:0] cmdRdIdx,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  flags,
  output logic [W-1:0]      rdData,
  output logic [CMDL_W-1:0] cmdLen,
  output logic [W-1:0]      cmdRdData,
  output logic [PTR_W-1:0]  rdPtr,
  output logic [PTR_W-1:0]  wrPtr
);

  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] RESP_LEN  = CNT_W'(2);

  logic [W-1:0] ring   [DEPTH];
  logic [W-1:0] cmdBuf [CMD_DEPTH];

  logic [CNT_W-1:0] nextCount;
  logic [PTR_W-1:0] rdPtrInc, wrPtrInc;

  always_comb begin
    nextCount = count + CNT_W'(strobes.push) - CNT_W'(strobes.pop);
    rdPtrInc  = (rdPtr == LAST_SLOT) ? '0 : rdPtr + 1'b1;
    wrPtrInc  = (wrPtr == LAST_SLOT) ? '0 : wrPtr + 1'b1;
  end

  // ring storage, no reset needed
  always_ff @(posedge clk) begin
    if (strobes.loadResp) begin
      ring[0] <= respStatus;
      ring[1] <= '0;
    end else if (strobes.push) begin
      ring[wrPtr] <= wrData;
    end
  end

  // occupancy, pointers, flags and read latch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      count  <= '0;
      rdPtr  <= '0;
      wrPtr  <= '0;
      flags  <= '0;
      rdData <= '0;
    end else if (strobes.clear) begin
      count <= '0;
      rdPtr <= '0;
      wrPtr <= '0;
      flags <= '0;
    end else if (strobes.loadResp) begin
      count <= RESP_LEN;
      rdPtr <= '0;
      wrPtr <= '0;
      flags <= RESP_LEN;
    end else begin
      count <= nextCount;
      if (strobes.pop) begin
        rdData <= strobes.popData ? ring[rdPtr] : '0;
      end
      if (nextCount == '0) begin
        rdPtr <= '0;
        wrPtr <= '0;
      end else begin
        if (strobes.pop)  rdPtr <= rdPtrInc;
        if (strobes.push) wrPtr <= wrPtrInc;
      end
    end
  end

  // command capture buffer
  always_ff @(posedge clk) begin
    if (strobes.cmdPush) begin
      cmdBuf[cmdLen[CPTR_W-1:0]] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdLen <= '0;
    end else if (strobes.cmdPush) begin
      cmdLen <= cmdLen + 1'b1;
    end
  end

  assign cmdRdData = cmdBuf[cmdRdIdx];

endmodule

// File: rtl/pio_xfer_fifo.sv
module pio_xfer_fifo
  import pio_fifo_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int CMD_DEPTH = 16,
  parameter int W         = 8,
  localparam int PTR_W    = $clog2(DEPTH),
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int CPTR_W   = $clog2(CMD_DEPTH),
  localparam int CMDL_W   = $clog2(CMD_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWrEn,
  input  logic [W-1:0]       hostWrData,
  input  logic               hostRdEn,
  input  logic               captureMode,
  input  logic [PHASE_W-1:0] phaseBits,
  input  logic               flush,
  input  logic               respLoad,
  input  logic [W-1:0]       respStatus,
  input  logic [CPTR_W-1:0]  cmdRdIdx,
  output logic [W-1:0]       rdData,
  output logic [CNT_W-1:0]   fifoCount,
  output logic [CNT_W-1:0]   fifoFlags,
  output logic               overrunErr,
  output logic               irqPulse,
  output logic [CMDL_W-1:0]  cmdLen,
  output logic [W-1:0]       cmdRdData
);

  fifoStrobes_t     strobes;
  logic [PTR_W-1:0] rdPtr, wrPtr;

  pio_fifo_ctrl #(.DEPTH(DEPTH), .CMD_DEPTH(CMD_DEPTH)) ctrl (
    .clk, .rstN, .hostWrEn, .hostRdEn, .captureMode, .phaseBits,
    .flush, .respLoad, .count(fifoCount), .cmdLen,
    .strobes, .overrunErr, .irqPulse
  );

  pio_fifo_data #(.DEPTH(DEPTH), .CMD_DEPTH(CMD_DEPTH), .W(W)) data (
    .clk, .rstN, .strobes, .wrData(hostWrData), .respStatus, .cmdRdIdx,
    .count(fifoCount), .flags(fifoFlags), .rdData, .cmdLen, .cmdRdData,
    .rdPtr, .wrPtr
  );

endmodule

// File: rtl/pio_fifo_chk.sv
module pio_fifo_chk #(
  parameter int DEPTH     = 16,
  parameter int CMD_DEPTH = 16,
  parameter int W         = 8,
  localparam int PTR_W    = $clog2(DEPTH),
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int CMDL_W   = $clog2(CMD_DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostWrEn,
  input logic              hostRdEn,
  input logic              captureMode,
  input logic              flush,
  input logic              respLoad,
  input logic [CNT_W-1:0]  fifoCount,
  input logic [W-1:0]      rdData,
  input logic              overrunErr,
  input logic              irqPulse,
  input logic [CMDL_W-1:0] cmdLen,
  input logic [PTR_W-1:0]  rdPtr,
  input logic [PTR_W-1:0]  wrPtr
);

  // R3
  overrun_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && !captureMode && !hostRdEn && !flush && !respLoad &&
     fifoCount == CNT_W'(DEPTH - 1)) |=> (overrunErr && $stable(fifoCount)));

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CNT_W'(DEPTH - 1));

  // R8
  drain_ptr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoCount == '0) |-> (rdPtr == '0 && wrPtr == '0));

  // R4
  capture_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (captureMode && hostWrEn && !hostRdEn && !flush && !respLoad)
      |=> $stable(fifoCount));

  // R4
  cmd_len_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdLen <= CMDL_W'(CMD_DEPTH));

  // R7
  empty_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdEn && !hostWrEn && !flush && !respLoad && fifoCount == '0)
      |=> (!irqPulse && $stable(rdData) && fifoCount == '0));

  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (fifoCount == '0));

  // R5
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqPulse) |-> ($past(hostRdEn) && $past(fifoCount) != '0));

endmodule

bind pio_xfer_fifo pio_fifo_chk #(.DEPTH(DEPTH), .CMD_DEPTH(CMD_DEPTH), .W(W)) chk (
  .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
  .captureMode(captureMode), .flush(flush), .respLoad(respLoad),
  .fifoCount(fifoCount), .rdData(rdData), .overrunErr(overrunErr),
  .irqPulse(irqPulse), .cmdLen(cmdLen), .rdPtr(rdPtr), .wrPtr(wrPtr)
);

// File: tb/pio_xfer_fifo_test.sv
module pio_xfer_fifo_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostWrEn = 1'b0;
  logic [7:0] hostWrData = '0;
  logic       hostRdEn = 1'b0;
  logic       captureMode = 1'b0;
  logic [2:0] phaseBits = 3'b111;
  logic       flush = 1'b0;
  logic       respLoad = 1'b0;
  logic [7:0] respStatus = '0;
  logic [3:0] cmdRdIdx = '0;
  logic [7:0] rdData;
  logic [4:0] fifoCount, fifoFlags, cmdLen;
  logic       overrunErr, irqPulse;
  logic [7:0] cmdRdData;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] expQ[$];
  string      reqQ[$];

  always #5 clk = ~clk;

  pio_xfer_fifo uut (
    .clk, .rstN, .hostWrEn, .hostWrData, .hostRdEn, .captureMode, .phaseBits,
    .flush, .respLoad, .respStatus, .cmdRdIdx, .rdData, .fifoCount, .fifoFlags,
    .overrunErr, .irqPulse, .cmdLen, .cmdRdData
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: every read strobe must match the oldest expected byte
  always @(negedge clk) begin
    if (rstN && irqPulse) begin
      if (expQ.size() == 0) begin
        chk("R7 unexpected read strobe", 1, 0);
      end else begin
        automatic logic [7:0] e = expQ.pop_front();
        automatic string r = reqQ.pop_front();
        chk(r, rdData, e);
      end
    end
  end

  task automatic wr(logic [7:0] b);
    hostWrEn = 1'b1; hostWrData = b;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic rd(logic [7:0] e, string r);
    expQ.push_back(e); reqQ.push_back(r);
    hostRdEn = 1'b1;
    @(negedge clk);
    hostRdEn = 1'b0;
  endtask

  initial begin
    #2_000_000;
    chk("watchdog expired", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", fifoCount, 0);
    chk("R1 flags", fifoFlags, 0);
    chk("R1 rdData", rdData, 0);
    chk("R1 cmdLen", cmdLen, 0);
    chk("R1 overrun", overrunErr, 0);
    chk("R1 irq", irqPulse, 0);

    // R2 basic writes, R5 in-order reads
    for (int i = 0; i < 5; i++) wr(8'hA0 + 8'(i));
    chk("R2 count after 5 writes", fifoCount, 5);
    for (int i = 0; i < 5; i++) rd(8'hA0 + 8'(i), "R5 data-in read");
    chk("R8 count after drain", fifoCount, 0);

    // R8 after drain, new write must read back from slot zero
    wr(8'h77);
    rd(8'h77, "R8 post-drain read");

    // R5 wrap: ring tail crosses the last slot without draining
    for (int i = 0; i < 10; i++) wr(8'h20 + 8'(i));
    for (int i = 0; i < 4; i++) rd(8'h20 + 8'(i), "R5 pre-wrap read");
    for (int i = 0; i < 8; i++) wr(8'h40 + 8'(i));
    chk("R5 count before wrapped drain", fifoCount, 14);
    for (int i = 4; i < 10; i++) rd(8'h20 + 8'(i), "R5 wrapped read");
    for (int i = 0; i < 8; i++) rd(8'h40 + 8'(i), "R5 wrapped read");

    // R3 overrun at fifteen entries
    for (int i = 0; i < 15; i++) wr(8'h10 + 8'(i));
    chk("R3 count at mark", fifoCount, 15);
    chk("R3 no overrun before", overrunErr, 0);
    wr(8'hEE);
    chk("R3 overrun pulse", overrunErr, 1);
    chk("R3 count held", fifoCount, 15);
    @(negedge clk);
    chk("R3 overrun one cycle", overrunErr, 0);
    for (int i = 0; i < 15; i++) rd(8'h10 + 8'(i), "R3 content after refusal");

    // R7 empty read keeps last byte (0x1E)
    hostRdEn = 1'b1;
    @(negedge clk);
    hostRdEn = 1'b0;
    chk("R7 rdData held", rdData, 8'h1E);
    chk("R7 no irq", irqPulse, 0);
    chk("R7 count", fifoCount, 0);

    // R6 outbound phase returns zero
    wr(8'h5C); wr(8'h5D);
    phaseBits = 3'b001;
    rd(8'h00, "R6 outbound read");
    rd(8'h00, "R6 outbound read");
    phaseBits = 3'b111;
    chk("R6 count consumed", fifoCount, 0);

    // R4 command capture
    captureMode = 1'b1;
    wr(8'hC1); wr(8'hC2); wr(8'hC3);
    chk("R4 cmdLen", cmdLen, 3);
    chk("R4 ring untouched", fifoCount, 0);
    cmdRdIdx = 4'd0; #1; chk("R4 cmd byte 0", cmdRdData, 8'hC1);
    cmdRdIdx = 4'd2; #1; chk("R4 cmd byte 2", cmdRdData, 8'hC3);
    for (int i = 0; i < 20; i++) wr(8'hD0 + 8'(i));
    chk("R4 cmdLen saturates", cmdLen, 16);
    cmdRdIdx = 4'd15; #1; chk("R4 last cmd byte", cmdRdData, 8'hDC);
    captureMode = 1'b0;

    // R9 completion reply
    wr(8'h99);
    respStatus = 8'h5A; respLoad = 1'b1;
    @(negedge clk);
    respLoad = 1'b0;
    chk("R9 count", fifoCount, 2);
    chk("R9 flags", fifoFlags, 2);
    rd(8'h5A, "R9 status byte");
    rd(8'h00, "R9 trailing zero");

    // R10 flush
    for (int i = 0; i < 4; i++) wr(8'h60 + 8'(i));
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    chk("R10 count cleared", fifoCount, 0);
    chk("R10 flags cleared", fifoFlags, 0);
    hostRdEn = 1'b1;
    @(negedge clk);
    hostRdEn = 1'b0;
    chk("R10 read after flush no irq", irqPulse, 0);

    // R11 simultaneous read and write
    wr(8'h81); wr(8'h82); wr(8'h83);
    expQ.push_back(8'h81); reqQ.push_back("R11 simultaneous read");
    hostRdEn = 1'b1; hostWrEn = 1'b1; hostWrData = 8'h84;
    @(negedge clk);
    hostRdEn = 1'b0; hostWrEn = 1'b0;
    chk("R11 count steady", fifoCount, 3);
    rd(8'h82, "R11 order");
    rd(8'h83, "R11 order");
    rd(8'h84, "R11 order");

    @(negedge clk);
    chk("scoreboard drained", expQ.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule